// File: doc/BRIEF.md
# Trigger-Matched Event Window Filter

This block sits between the per-channel timing digitizers of a multi-channel hit readout and the serial link that carries hits off chip. Each incoming hit record holds a coarse timestamp in 200 ns ticks, a fine timestamp and a channel number. The block stores it in a record queue. Records leave the queue only when an external validation pulse has selected them, or when they have grown too old for any later pulse to select them. Old records are discarded and counted. Records that are sent go out through a valid/ready handshake.

A validation pulse captured at coarse time T opens a window over the coarse timestamps from T − offset to T − offset + width, where offset (0 to 7 ticks) and width (0 to 15 ticks) come from configuration inputs sampled at the pulse. Up to four windows can wait in a pending queue, and they are served oldest first. A bypass input turns matching off and forwards every record in arrival order.

Top module: `evwin_filter`

## Requirements
- R1: After reset `out_valid_o` is 0, `in_ready_o` is 1, `drop_count_o` is 0, `pend_ovf_o` is 0 and the internal coarse time is 0. The coarse time advances by one on each clock with `tick_i` high and wraps modulo 2^TS_W.
- R2: While `bypass_i` is 1, every stored record is offered at the output in arrival order, whatever its timestamp. No record is discarded, and validation pulses are not queued.
- R3: With bypass off and no pending window, a head record whose age (now − coarse timestamp, modulo 2^TS_W, read as a signed value) is 7 ticks or less is held: the output stays invalid and the record is not discarded.
- R4: A validation pulse at coarse time T queues a window with start L = T − offset and the width from that cycle. A head record whose signed distance d = ts − L satisfies 0 ≤ d ≤ width is offered at the output.
- R5: A head record with d < 0 against the oldest pending window is discarded, and `drop_count_o` increases by one.
- R6: A head record with d > width retires the oldest pending window without being removed. It is then judged against the next window, or held under R3.
- R7: With bypass off and no pending window, a head record older than 7 ticks is discarded, and `drop_count_o` increases by one.
- R8: With the record queue empty, the oldest window retires once now − L, read as a signed value, exceeds its width.
- R9: The pending window queue holds 4 entries. A pulse arriving with bypass off while the queue is full is lost and sets `pend_ovf_o`, which stays at 1 until reset.
- R10: While `out_valid_o` is 1 and `out_ready_i` is 0, the offered record stays on the output unchanged. A record leaves only by being accepted or by being discarded.
- R11: All timestamp comparisons are taken modulo 2^TS_W, so a window that spans the rollover of the coarse count matches records on both sides of it.
- R12: The record queue holds 8 records. `in_ready_o` is 0 when the queue is full, and a write offered then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Advance coarse time by one 200 ns step |
| bypass_i | input | 1 | 1: forward every record without matching |
| cfg_offset_i | input | OFS_W (3) | Window offset in ticks, sampled at the pulse |
| cfg_width_i | input | WID_W (4) | Window width in ticks, sampled at the pulse |
| vld_pulse_i | input | 1 | External validation pulse, one cycle |
| in_valid_i | input | 1 | Hit record write strobe |
| in_ready_o | output | 1 | Record queue can accept a record |
| in_coarse_i | input | TS_W (8) | Coarse timestamp of the record |
| in_fine_i | input | FINE_W (12) | Fine timestamp of the record |
| in_chan_i | input | CH_W (5) | Channel number of the record |
| out_valid_o | output | 1 | Selected record offered downstream |
| out_ready_i | input | 1 | Downstream accepts the offered record |
| out_coarse_o | output | TS_W (8) | Coarse timestamp of the offered record |
| out_fine_o | output | FINE_W (12) | Fine timestamp of the offered record |
| out_chan_o | output | CH_W (5) | Channel of the offered record |
| drop_count_o | output | CNT_W (16) | Number of discarded records, wrapping |
| pend_ovf_o | output | 1 | Sticky pending-window overflow flag |

## Verification
The hardest case to reach from the ports is a window whose range crosses the rollover of the coarse count. The internal time can be set only by ticking, so the stimulus advances it to just below the wrap point and stores one record on each side of the boundary. It then ticks past zero and sends a pulse whose offset places the window start before the wrap. Holding `tick_i` low while pulses arrive keeps windows from expiring, which fills the pending queue so the overflow can be observed. Ordered pushes behind an early head record exercise discard, forward and retire in turn.

// File: rtl/evw_pkg.sv
`timescale 1ns/1ps
package evw_pkg;
  // Decision taken for the record at the head of the queue in one cycle
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_HOLD,
    ACT_FWD,
    ACT_DROP,
    ACT_RETIRE
  } evw_act_e;
endpackage

// File: rtl/evw_fifo.sv
`timescale 1ns/1ps
module evw_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  mem_q [DEPTH];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (wr_en) begin
      wr_ptr_d = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    end
    if (rd_en) begin
      rd_ptr_d = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
    cnt_d = cnt_q + CW'(wr_en) - CW'(rd_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage slots: no reset, written only under their own enable
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_ptr_q == AW'(i))) begin
        mem_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem_q[rd_ptr_q];
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));

  // R12: the owner never writes a full queue
  p_no_wr_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  // R10: a record is only removed when one is present
  p_no_rd_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);
endmodule

// File: rtl/evw_match.sv
`timescale 1ns/1ps
module evw_match
  import evw_pkg::*;
#(
  parameter int TS_W    = 8,
  parameter int WID_W   = 4,
  parameter int OFS_MAX = 7
) (
  input  logic             bypass_i,
  input  logic             rec_vld_i,
  input  logic [TS_W-1:0]  rec_ts_i,
  input  logic             win_vld_i,
  input  logic [TS_W-1:0]  win_lo_i,
  input  logic [WID_W-1:0] win_wid_i,
  input  logic [TS_W-1:0]  now_i,
  output evw_act_e         act_o
);
  logic [TS_W-1:0]      raw_win, raw_age, raw_end;
  logic signed [TS_W:0] s_win, s_age, s_end, s_wid, s_lim;

  always_comb begin
    raw_win = rec_ts_i - win_lo_i;
    raw_age = now_i - rec_ts_i;
    raw_end = now_i - win_lo_i;
    s_win   = signed'({raw_win[TS_W-1], raw_win});
    s_age   = signed'({raw_age[TS_W-1], raw_age});
    s_end   = signed'({raw_end[TS_W-1], raw_end});
    s_wid   = signed'({{(TS_W + 1 - WID_W){1'b0}}, win_wid_i});
    s_lim   = signed'((TS_W + 1)'(OFS_MAX));
  end

  always_comb begin
    act_o = ACT_IDLE;
    if (!rec_vld_i) begin
      if (win_vld_i && !bypass_i && (s_end > s_wid)) act_o = ACT_RETIRE;
    end else if (bypass_i) begin
      act_o = ACT_FWD;
    end else if (win_vld_i) begin
      if (s_win < 0)           act_o = ACT_DROP;
      else if (s_win <= s_wid) act_o = ACT_FWD;
      else                     act_o = ACT_RETIRE;
    end else begin
      act_o = (s_age > s_lim) ? ACT_DROP : ACT_HOLD;
    end
  end

  // R4: matching without bypass needs an open window
  always_comb begin
    if (act_o == ACT_FWD && !bypass_i) begin
      a_fwd_needs_win_r4: assert (win_vld_i && rec_vld_i);
    end
  end
endmodule

// File: rtl/evwin_filter.sv
`timescale 1ns/1ps
module evwin_filter
  import evw_pkg::*;
#(
  parameter int TS_W      = 8,
  parameter int FINE_W    = 12,
  parameter int CH_W      = 5,
  parameter int OFS_W     = 3,
  parameter int WID_W     = 4,
  parameter int REC_DEPTH = 8,
  parameter int WIN_DEPTH = 4,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bypass_i,
  input  logic [OFS_W-1:0]  cfg_offset_i,
  input  logic [WID_W-1:0]  cfg_width_i,
  input  logic              vld_pulse_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [TS_W-1:0]   in_coarse_i,
  input  logic [FINE_W-1:0] in_fine_i,
  input  logic [CH_W-1:0]   in_chan_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [TS_W-1:0]   out_coarse_o,
  output logic [FINE_W-1:0] out_fine_o,
  output logic [CH_W-1:0]   out_chan_o,
  output logic [CNT_W-1:0]  drop_count_o,
  output logic              pend_ovf_o
);
  localparam int OFS_MAX = (1 << OFS_W) - 1;
  localparam int REC_W   = TS_W + FINE_W + CH_W;
  localparam int WIN_W   = TS_W + WID_W;

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_s1_q, rst_s2_q, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_ns = rst_s2_q;

  // Coarse time base
  logic [TS_W-1:0] now_q, now_d;
  always_comb now_d = tick_i ? now_q + 1'b1 : now_q;

  // Record queue
  logic             rec_wr, rec_rd, rec_empty, rec_full;
  logic [REC_W-1:0] rec_wdata, rec_rdata;
  assign rec_wdata = {in_coarse_i, in_fine_i, in_chan_i};
  assign rec_wr    = in_valid_i && !rec_full;

  evw_fifo #(.W(REC_W), .DEPTH(REC_DEPTH)) i_rec_fifo (
    .clk     (clk),
    .rst_n   (rst_ns),
    .wr_en   (rec_wr),
    .wr_data (rec_wdata),
    .rd_en   (rec_rd),
    .rd_data (rec_rdata),
    .empty   (rec_empty),
    .full    (rec_full)
  );

  logic [TS_W-1:0]   head_ts;
  logic [FINE_W-1:0] head_fine;
  logic [CH_W-1:0]   head_chan;
  assign {head_ts, head_fine, head_chan} = rec_rdata;

  // Pending window queue
  logic             win_push, win_pop, win_empty, win_full;
  logic [TS_W-1:0]  new_lo, head_lo;
  logic [WID_W-1:0] head_wid;
  logic [WIN_W-1:0] win_wdata, win_rdata;
  assign new_lo    = now_q - {{(TS_W - OFS_W){1'b0}}, cfg_offset_i};
  assign win_wdata = {new_lo, cfg_width_i};
  assign win_push  = vld_pulse_i && !bypass_i && !win_full;

  evw_fifo #(.W(WIN_W), .DEPTH(WIN_DEPTH)) i_win_fifo (
    .clk     (clk),
    .rst_n   (rst_ns),
    .wr_en   (win_push),
    .wr_data (win_wdata),
    .rd_en   (win_pop),
    .rd_data (win_rdata),
    .empty   (win_empty),
    .full    (win_full)
  );
  assign {head_lo, head_wid} = win_rdata;

  // Decision for the head record
  evw_act_e act;
  evw_match #(.TS_W(TS_W), .WID_W(WID_W), .OFS_MAX(OFS_MAX)) i_match (
    .bypass_i  (bypass_i),
    .rec_vld_i (!rec_empty),
    .rec_ts_i  (head_ts),
    .win_vld_i (!win_empty),
    .win_lo_i  (head_lo),
    .win_wid_i (head_wid),
    .now_i     (now_q),
    .act_o     (act)
  );

  assign out_valid_o  = (act == ACT_FWD);
  assign rec_rd       = (out_valid_o && out_ready_i) || (act == ACT_DROP);
  assign win_pop      = (act == ACT_RETIRE);
  assign out_coarse_o = head_ts;
  assign out_fine_o   = head_fine;
  assign out_chan_o   = head_chan;
  assign in_ready_o   = !rec_full;

  // Drop counter and overflow flag
  logic [CNT_W-1:0] drop_q, drop_d;
  logic             ovf_q, ovf_d;
  always_comb begin
    drop_d = (act == ACT_DROP) ? drop_q + 1'b1 : drop_q;
    ovf_d  = ovf_q || (vld_pulse_i && !bypass_i && win_full);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      now_q  <= '0;
      drop_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      now_q  <= now_d;
      drop_q <= drop_d;
      ovf_q  <= ovf_d;
    end
  end

  assign drop_count_o = drop_q;
  assign pend_ovf_o   = ovf_q;

  // R10: an offered, unaccepted record stays put unless the mode changes
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    (out_valid_o && !out_ready_i) |=>
      ((out_valid_o && $stable(out_chan_o) && $stable(out_coarse_o) && $stable(out_fine_o))
       || (bypass_i != $past(bypass_i))));
  // R9: overflow flag is sticky
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    pend_ovf_o |=> pend_ovf_o);
  // R9: a pulse on a full pending queue raises the flag
  p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (vld_pulse_i && !bypass_i && win_full) |=> pend_ovf_o);
  // R2: in bypass a stored record is always offered
  p_bypass_fwd_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (bypass_i && !rec_empty) |-> out_valid_o);
  // R12: ready output mirrors queue occupancy
  p_ready_full_r12: assert property (@(posedge clk) disable iff (!rst_ns)
    (rec_full && !rec_rd) |=> !in_ready_o);
endmodule

// File: tb/test_evwin_filter.sv
`timescale 1ns/1ps
module test_evwin_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, bypass, vld_pulse, in_valid, out_ready;
  logic [2:0]  cfg_offset;
  logic [3:0]  cfg_width;
  logic [7:0]  in_coarse;
  logic [11:0] in_fine;
  logic [4:0]  in_chan;
  logic        in_ready, out_valid, pend_ovf;
  logic [7:0]  out_coarse;
  logic [11:0] out_fine;
  logic [4:0]  out_chan;
  logic [15:0] drop_count;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] now_m = 8'd0;
  logic [15:0] drop_base;
  bit done = 0;

  always #2.5 clk = ~clk;

  evwin_filter i_evwin_filter (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bypass_i(bypass),
    .cfg_offset_i(cfg_offset), .cfg_width_i(cfg_width), .vld_pulse_i(vld_pulse),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_coarse_i(in_coarse),
    .in_fine_i(in_fine), .in_chan_i(in_chan), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_coarse_o(out_coarse), .out_fine_o(out_fine),
    .out_chan_o(out_chan), .drop_count_o(drop_count), .pend_ovf_o(pend_ovf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(posedge clk); @(negedge clk); tick = 1'b0;
      now_m = now_m + 8'd1;
    end
  endtask

  task automatic push(input logic [7:0] ts, input logic [4:0] ch);
    in_valid = 1'b1; in_coarse = ts; in_chan = ch; in_fine = {7'd0, ch};
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse();
    vld_pulse = 1'b1; @(posedge clk); @(negedge clk); vld_pulse = 1'b0;
  endtask

  task automatic accept_expect(input string req, input logic [4:0] ch);
    check({req, " valid"}, out_valid, 1);
    check({req, " chan"}, out_chan, ch);
    check({req, " fine"}, out_fine, {7'd0, ch});
    out_ready = 1'b1; @(posedge clk); @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 out_valid", out_valid, 0);
    check("R1 in_ready", in_ready, 1);
    check("R1 drop_count", drop_count, 0);
    check("R1 pend_ovf", pend_ovf, 0);
  endtask

  task automatic t_bypass();
    bypass = 1'b1;
    push(now_m - 8'd100, 5'd1);
    push(now_m - 8'd50, 5'd2);
    pulse();
    push(now_m + 8'd20, 5'd3);
    accept_expect("R2 first", 5'd1);
    accept_expect("R2 second", 5'd2);
    accept_expect("R2 third", 5'd3);
    check("R2 no drops", drop_count, 0);
    check("R2 empty", out_valid, 0);
    bypass = 1'b0;
    cycles(1);
  endtask

  task automatic t_age();
    drop_base = drop_count;
    push(now_m - 8'd3, 5'd5);
    cycles(3);
    check("R3 held", out_valid, 0);
    check("R3 not dropped", drop_count, drop_base);
    do_tick(4);
    check("R3 held at age 7", drop_count, drop_base);
    do_tick(1);
    cycles(2);
    check("R7 aged drop", drop_count, drop_base + 16'd1);
    check("R7 nothing out", out_valid, 0);
  endtask

  task automatic t_window();
    logic [7:0] n;
    n = now_m;
    drop_base = drop_count;
    cfg_offset = 3'd4; cfg_width = 4'd3;
    push(n - 8'd6, 5'd1);
    push(n - 8'd4, 5'd2);
    push(n - 8'd1, 5'd3);
    push(n,        5'd4);
    cycles(1);
    check("R3 held before pulse", drop_count, drop_base);
    pulse();
    cycles(2);
    check("R5 early drop", drop_count, drop_base + 16'd1);
    check("R4 start edge valid", out_valid, 1);
    check("R4 start edge chan", out_chan, 2);
    cycles(2);
    check("R10 hold valid", out_valid, 1);
    check("R10 hold chan", out_chan, 2);
    check("R10 hold coarse", out_coarse, n - 8'd4);
    accept_expect("R4 start", 5'd2);
    accept_expect("R4 end edge", 5'd3);
    cycles(2);
    check("R6 retire leaves record", out_valid, 0);
    check("R6 no drop", drop_count, drop_base + 16'd1);
    cfg_offset = 3'd0; cfg_width = 4'd0;
    pulse();
    cycles(1);
    accept_expect("R6 next window", 5'd4);
    do_tick(1);
    cycles(2);
    push(n, 5'd6);
    cycles(2);
    check("R8 window retired when empty", out_valid, 0);
    bypass = 1'b1;
    cycles(1);
    accept_expect("R2 flush", 5'd6);
    bypass = 1'b0;
    cycles(1);
  endtask

  task automatic t_overflow();
    cfg_offset = 3'd0; cfg_width = 4'd0;
    for (int i = 0; i < 4; i++) pulse();
    cycles(1);
    check("R9 four fit", pend_ovf, 0);
    pulse();
    cycles(1);
    check("R9 fifth overflows", pend_ovf, 1);
    do_tick(1);
    cycles(6);
    check("R9 sticky", pend_ovf, 1);
  endtask

  task automatic t_wrap();
    int steps;
    steps = int'(8'd254 - now_m);
    if (steps > 0) do_tick(steps);
    check("R11 time base at 254", now_m, 254);
    push(8'd253, 5'd7);
    push(8'd1, 5'd8);
    do_tick(3);
    check("R11 held before pulse", out_valid, 0);
    cfg_offset = 3'd4; cfg_width = 4'd5;
    pulse();
    cycles(1);
    accept_expect("R11 before wrap", 5'd7);
    accept_expect("R11 after wrap", 5'd8);
    do_tick(2);
    cycles(2);
  endtask

  task automatic t_full();
    for (int i = 0; i < 8; i++) push(now_m, 5'(10 + i));
    check("R12 ready low when full", in_ready, 0);
    push(now_m, 5'd31);
    bypass = 1'b1;
    cycles(1);
    for (int i = 0; i < 8; i++) accept_expect("R12 order", 5'(10 + i));
    check("R12 extra write ignored", out_valid, 0);
    bypass = 1'b0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 0; bypass = 0; vld_pulse = 0; in_valid = 0; out_ready = 0;
    cfg_offset = '0; cfg_width = '0; in_coarse = '0; in_fine = '0; in_chan = '0;
    cycles(4);
    rst_n = 1'b1;
    cycles(4);
    t_reset();
    t_bypass();
    t_age();
    t_window();
    t_overflow();
    t_wrap();
    t_full();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule